// File: doc/BRIEF.md
# Special-Function Output Port Multiplexer

This block decides what appears on a group of four microcontroller output pins. Each pin normally shows a one-bit data latch that the CPU writes and reads over a small register bus. Build-time parameters can instead give a pin a special function: a complementary tone pair on pins 0 and 1, a complementary clock pair on pins 1 and 2, a gated timer clock on pin 3, or a serial-ready flag on pin 3. In each complementary pair, the latch of the first pin turns both outputs on and off. The latch of the partner pin stays a plain read/write bit that has no effect on its pin.

Every source arrives as an ordinary signal, and everything is sampled in the `clk_i` domain: the tone, the high-speed and low-speed clocks, the timer clock and the serial-ready level. The clock pair can use a divided copy of the low-speed clock, made inside the block. Gating is hazard-free because each gate's enable register loads its latch only in a cycle where the gated source is low. Pins set up as three-state stay undriven until software first writes their latch. A parameter combination that is not allowed raises a static configuration-error flag, and the affected pin falls back to driving its latch.

Top module: `spo_port_mux`

## Requirements
- R1: All latches and the timer-clock-output control bit reset to 0. `rdata_o` combinationally returns the stored bit at `addr_i` 0..3 (pin latches 0..3) and 4 (control bit), whatever the pin modes. Addresses 5..7 read 0, and writes to them change nothing.
- R2: With the tone option on pin 0, pin 0 equals `buzz_i` AND the tone gate, and pin 1 (if it is set up as the inverted tone) equals the complement of that. The tone gate follows latch 0 only. Latch 1 has no effect on pin 1.
- R3: On each rising clock edge, a gate enable loads its latch value only if the gated source is low; otherwise it holds. While a gate is off, the true output is 0 and the complementary output is 1.
- R4: Selecting the inverted tone on pin 1 while pin 0 is a plain data output sets `cfg_err_o` = 1, and pin 1 then drives latch 1. Selecting the inverted clock on pin 2 while pin 1 is not in clock-out mode also sets `cfg_err_o`, and pin 2 then drives latch 2. Otherwise `cfg_err_o` = 0.
- R5: In clock-out mode, pin 1 equals the selected clock AND a gate that follows latch 1. Pin 2, if it is set up as the inverted clock, is the complement of pin 1. Latch 2 has no effect on pin 2.
- R6: The clock source parameter selects `fast_clk_i` (0), `slow_clk_i` (1), or the low-speed clock divided by 2^DIV_W (2). The divided clock is bit DIV_W-1 of a counter that resets to 0 and counts the clock cycles in which `slow_clk_i` is high and was low one cycle earlier.
- R7: With pin 3 in timer mode, a control bit of 1 makes pin 3 equal to `tclk_i` AND a gate that follows latch 3. A control bit of 0 makes pin 3 equal to latch 3.
- R8: With pin 3 in serial-ready mode, pin 3 equals `srdy_i`, `oe_o[3]` is 1, and latch 3 is only a read/write bit.
- R9: A pin marked three-state in TRI_MASK has `oe_o` = 0 after reset. It rises after the first write to that pin's latch address and then stays 1. All other pins have `oe_o` = 1.
- R10: A pin with no special function active drives its latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 1 | Write data |
| rdata_o | output | 1 | Read data of the addressed register |
| buzz_i | input | 1 | Tone signal |
| fast_clk_i | input | 1 | High-speed clock source |
| slow_clk_i | input | 1 | Low-speed clock source |
| tclk_i | input | 1 | Timer clock |
| srdy_i | input | 1 | Serial interface ready level |
| pin_o | output | 4 | Pin output values |
| oe_o | output | 4 | Pin output enables |
| cfg_err_o | output | 1 | Illegal parameter combination |

## Verification
The assertions assume that every source signal (tone, clocks, timer clock, serial-ready) is a level that is stable across each `clk_i` edge. They also assume that write strobe, address and data change only between edges. The stimulus drives all of these a fixed time after the rising edge and toggles the sources at random cycle boundaries, so every gate sees both high and low samples. The register address is drawn from 0..5, which includes an unmapped value, so the readback and sticky-enable properties also see writes that must be ignored. Five instances with different parameter sets share this stimulus, and one of them has both illegal pairings.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic       {A_DC, A_BUZ}                    pin_a_mode_e;
  typedef enum logic [1:0] {B_DC, B_BUZN, B_CLK}            pin_b_mode_e;
  typedef enum logic       {C_DC, C_CLKN}                   pin_c_mode_e;
  typedef enum logic       {D_TCLK, D_SRDY}                 pin_d_mode_e;
  typedef enum logic [1:0] {CS_FAST, CS_SLOW, CS_SLOW_DIV}  clk_sel_e;
endpackage

// File: rtl/spo_regs.sv
module spo_regs #(
  parameter int NP = 4,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wdata_i,
  output logic          rdata_o,
  output logic [NP-1:0] lat_o,
  output logic          ctl_o,
  output logic [NP-1:0] seen_o
);
  localparam int CTL_ADDR = NP;

  logic [NP-1:0] lat_q, seen_q;
  logic          ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      seen_q <= '0;
      ctl_q  <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NP; i++) begin
        if (addr_i == AW'(i)) begin
          lat_q[i]  <= wdata_i;
          seen_q[i] <= 1'b1;
        end
      end
      if (addr_i == AW'(CTL_ADDR)) ctl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 1'b0;
    for (int i = 0; i < NP; i++)
      if (addr_i == AW'(i)) rdata_o = lat_q[i];
    if (addr_i == AW'(CTL_ADDR)) rdata_o = ctl_q;
  end

  assign lat_o  = lat_q;
  assign ctl_o  = ctl_q;
  assign seen_o = seen_q;

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(addr_i) <= AW'(CTL_ADDR) && addr_i == $past(addr_i))
      |-> rdata_o == $past(wdata_i)); // R1
  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q & $past(seen_q)) == $past(seen_q)); // R9
  AST_OE_RISE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != $past(seen_q)) |-> $past(we_i)); // R9
endmodule

// File: rtl/spo_clkdiv.sv
module spo_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic div_o
);
  logic             slow_q;
  logic [DIV_W-1:0] cnt_q;
  logic             rise;

  assign rise = slow_i & ~slow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      slow_q <= slow_i;
      if (rise) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_o = cnt_q[DIV_W-1];

  AST_DIV_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o != $past(div_o)) |-> $past(rise)); // R6
endmodule

// File: rtl/spo_gate.sv
module spo_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic en_i,
  output logic gated_o
);
  logic en_q;

  // enable only moves while the source is low: no truncated pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (!src_i) en_q <= en_i;
  end

  assign gated_o = src_i & en_q;

  AST_GATE_SWITCH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> !$past(src_i)); // R3
endmodule

// File: rtl/spo_port_mux.sv
module spo_port_mux
  import spo_pkg::*;
#(
  parameter pin_a_mode_e A_MODE   = A_BUZ,
  parameter pin_b_mode_e B_MODE   = B_BUZN,
  parameter pin_c_mode_e C_MODE   = C_DC,
  parameter pin_d_mode_e D_MODE   = D_TCLK,
  parameter clk_sel_e    CLK_SEL  = CS_SLOW_DIV,
  parameter int          DIV_W    = 2,
  parameter logic [3:0]  TRI_MASK = 4'b0101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic       wdata_i,
  output logic       rdata_o,
  input  logic       buzz_i,
  input  logic       fast_clk_i,
  input  logic       slow_clk_i,
  input  logic       tclk_i,
  input  logic       srdy_i,
  output logic [3:0] pin_o,
  output logic [3:0] oe_o,
  output logic       cfg_err_o
);
  localparam int NP = 4;
  localparam int AW = 3;

  localparam bit A_IS_BUZ  = (A_MODE == A_BUZ);
  localparam bit B_REQ_BZN = (B_MODE == B_BUZN);
  localparam bit B_BAD     = B_REQ_BZN && !A_IS_BUZ;
  localparam bit B_IS_BZN  = B_REQ_BZN && A_IS_BUZ;
  localparam bit B_IS_CLK  = (B_MODE == B_CLK);
  localparam bit C_REQ     = (C_MODE == C_CLKN);
  localparam bit C_BAD     = C_REQ && !B_IS_CLK;
  localparam bit C_IS_CLKN = C_REQ && B_IS_CLK;
  localparam bit D_IS_SRDY = (D_MODE == D_SRDY);

  logic [NP-1:0] lat, seen;
  logic          ctl;
  logic          div_clk, co_src;
  logic          bz_g, co_g, tc_g;
  logic [2:0]    src_vec;

  spo_regs #(.NP(NP), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .lat_o   (lat),
    .ctl_o   (ctl),
    .seen_o  (seen)
  );

  spo_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (slow_clk_i),
    .div_o  (div_clk)
  );

  assign src_vec = {div_clk, slow_clk_i, fast_clk_i};
  assign co_src  = src_vec[CLK_SEL];

  spo_gate u_bz_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(buzz_i), .en_i(lat[0]), .gated_o(bz_g)
  );
  spo_gate u_co_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(co_src), .en_i(lat[1]), .gated_o(co_g)
  );
  spo_gate u_tc_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(tclk_i), .en_i(lat[3]), .gated_o(tc_g)
  );

  always_comb begin
    pin_o[0] = A_IS_BUZ ? bz_g : lat[0];
    if (B_IS_BZN)      pin_o[1] = ~bz_g;
    else if (B_IS_CLK) pin_o[1] = co_g;
    else               pin_o[1] = lat[1];
    pin_o[2] = C_IS_CLKN ? ~co_g : lat[2];
    if (D_IS_SRDY)     pin_o[3] = srdy_i;
    else               pin_o[3] = ctl ? tc_g : lat[3];
  end

  for (genvar i = 0; i < NP; i++) begin : g_oe
    if (D_IS_SRDY && i == 3) begin : g_push
      assign oe_o[i] = 1'b1;
    end else if (TRI_MASK[i]) begin : g_tri
      assign oe_o[i] = seen[i];
    end else begin : g_two
      assign oe_o[i] = 1'b1;
    end
  end

  assign cfg_err_o = B_BAD | C_BAD;

  if (!D_IS_SRDY) begin : g_tclk_chk
    AST_TCLK_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl && $past(!lat[3]) && $past(!tclk_i)) |-> !pin_o[3]); // R7
  end
  if (B_IS_BZN) begin : g_bz_chk
    AST_BZ_OFF_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!lat[0]) && $past(!buzz_i)) |-> (!pin_o[0] && pin_o[1])); // R3
  end
endmodule

// File: tb/spo_port_mux_bench.sv
`timescale 1ns/1ps
module spo_port_mux_bench;
  import spo_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, we, wdata, buzz, fclk, sclk, tclk, srdy;
  logic [2:0] addr;
  logic [3:0] pin_w [5];
  logic [3:0] oe_w  [5];
  logic       rd_w  [5];
  logic       err_w [5];

  // per-instance configuration as seen by the bench model
  localparam bit   CFG_A [5] = '{1, 0, 1, 0, 0};
  localparam int   CFG_B [5] = '{1, 2, 2, 1, 2};
  localparam bit   CFG_C [5] = '{0, 1, 1, 1, 0};
  localparam bit   CFG_D [5] = '{0, 1, 0, 1, 0};
  localparam int   CFG_S [5] = '{2, 2, 1, 0, 0};
  localparam logic [3:0] CFG_T [5] = '{4'b0101, 4'b1111, 4'b0000, 4'b1010, 4'b0010};

  spo_port_mux #(.A_MODE(A_BUZ), .B_MODE(B_BUZN), .C_MODE(C_DC), .D_MODE(D_TCLK),
    .CLK_SEL(CS_SLOW_DIV), .DIV_W(2), .TRI_MASK(4'b0101)) u_spo_port_mux (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_w[0]),
    .buzz_i(buzz), .fast_clk_i(fclk), .slow_clk_i(sclk), .tclk_i(tclk), .srdy_i(srdy),
    .pin_o(pin_w[0]), .oe_o(oe_w[0]), .cfg_err_o(err_w[0]));
  spo_port_mux #(.A_MODE(A_DC), .B_MODE(B_CLK), .C_MODE(C_CLKN), .D_MODE(D_SRDY),
    .CLK_SEL(CS_SLOW_DIV), .DIV_W(2), .TRI_MASK(4'b1111)) u_spo_port_mux_k1 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_w[1]),
    .buzz_i(buzz), .fast_clk_i(fclk), .slow_clk_i(sclk), .tclk_i(tclk), .srdy_i(srdy),
    .pin_o(pin_w[1]), .oe_o(oe_w[1]), .cfg_err_o(err_w[1]));
  spo_port_mux #(.A_MODE(A_BUZ), .B_MODE(B_CLK), .C_MODE(C_CLKN), .D_MODE(D_TCLK),
    .CLK_SEL(CS_SLOW), .DIV_W(2), .TRI_MASK(4'b0000)) u_spo_port_mux_k2 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_w[2]),
    .buzz_i(buzz), .fast_clk_i(fclk), .slow_clk_i(sclk), .tclk_i(tclk), .srdy_i(srdy),
    .pin_o(pin_w[2]), .oe_o(oe_w[2]), .cfg_err_o(err_w[2]));
  spo_port_mux #(.A_MODE(A_DC), .B_MODE(B_BUZN), .C_MODE(C_CLKN), .D_MODE(D_SRDY),
    .CLK_SEL(CS_FAST), .DIV_W(2), .TRI_MASK(4'b1010)) u_spo_port_mux_k3 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_w[3]),
    .buzz_i(buzz), .fast_clk_i(fclk), .slow_clk_i(sclk), .tclk_i(tclk), .srdy_i(srdy),
    .pin_o(pin_w[3]), .oe_o(oe_w[3]), .cfg_err_o(err_w[3]));
  spo_port_mux #(.A_MODE(A_DC), .B_MODE(B_CLK), .C_MODE(C_DC), .D_MODE(D_TCLK),
    .CLK_SEL(CS_FAST), .DIV_W(2), .TRI_MASK(4'b0010)) u_spo_port_mux_k4 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_w[4]),
    .buzz_i(buzz), .fast_clk_i(fclk), .slow_clk_i(sclk), .tclk_i(tclk), .srdy_i(srdy),
    .pin_o(pin_w[4]), .oe_o(oe_w[4]), .cfg_err_o(err_w[4]));

  int checks = 0;
  int errors = 0;

  bit       m_lat [5][4];
  bit       m_oef [5][4];
  bit       m_ctl [5];
  bit       m_enbz [5];
  bit       m_enco [5];
  bit       m_entc [5];
  bit       m_sq;
  bit [1:0] m_cnt;

  function automatic int b_eff(int k);
    return (CFG_B[k] == 1 && !CFG_A[k]) ? 0 : CFG_B[k];
  endfunction

  function automatic bit c_eff(int k);
    return CFG_C[k] && b_eff(k) == 2;
  endfunction

  function automatic bit src_co(int k);
    if (CFG_S[k] == 0) return fclk;
    if (CFG_S[k] == 1) return sclk;
    return m_cnt[1];
  endfunction

  function automatic bit exp_pin(int k, int i);
    bit bz = buzz & m_enbz[k];
    bit co = src_co(k) & m_enco[k];
    case (i)
      0: return CFG_A[k] ? bz : m_lat[k][0];
      1: return (b_eff(k) == 1) ? ~bz : (b_eff(k) == 2) ? co : m_lat[k][1];
      2: return c_eff(k) ? ~co : m_lat[k][2];
      default: return CFG_D[k] ? srdy : (m_ctl[k] ? (tclk & m_entc[k]) : m_lat[k][3]);
    endcase
  endfunction

  function automatic string pin_tag(int k, int i);
    case (i)
      0: return CFG_A[k] ? ((m_enbz[k] != m_lat[k][0]) ? "R3" : "R2") : "R10";
      1: begin
        if (CFG_B[k] == 1 && !CFG_A[k]) return "R4";
        if (b_eff(k) == 1) return "R2";
        if (b_eff(k) == 2) return (CFG_S[k] == 2) ? "R6" : "R5";
        return "R10";
      end
      2: return c_eff(k) ? "R5" : (CFG_C[k] ? "R4" : "R10");
      default: return CFG_D[k] ? "R8" : "R7";
    endcase
  endfunction

  task automatic chk(string tag, int k, string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst%0d %s got %0b expected %0b", tag, k, what, got, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 5; k++) begin
      bit exp_rd, exp_err;
      for (int i = 0; i < 4; i++) begin
        bit exp_oe = (i == 3 && CFG_D[k]) ? 1'b1 : (CFG_T[k][i] ? m_oef[k][i] : 1'b1);
        chk(pin_tag(k, i), k, $sformatf("pin%0d", i), pin_w[k][i], exp_pin(k, i));
        chk((i == 3 && CFG_D[k]) ? "R8" : "R9", k, $sformatf("oe%0d", i), oe_w[k][i], exp_oe);
      end
      exp_rd = (addr < 3'd4) ? m_lat[k][addr[1:0]] : (addr == 3'd4) ? m_ctl[k] : 1'b0;
      chk("R1", k, $sformatf("rdata@%0d", addr), rd_w[k], exp_rd);
      exp_err = (CFG_B[k] == 1 && !CFG_A[k]) || (CFG_C[k] && b_eff(k) != 2);
      chk("R4", k, "cfg_err", err_w[k], exp_err);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 4; i++) begin
        m_lat[k][i] = 1'b0;
        m_oef[k][i] = 1'b0;
      end
      m_ctl[k] = 1'b0; m_enbz[k] = 1'b0; m_enco[k] = 1'b0; m_entc[k] = 1'b0;
    end
    m_sq = 1'b0;
    m_cnt = 2'b00;
  endtask

  task automatic model_step();
    for (int k = 0; k < 5; k++) begin
      bit so = src_co(k);
      if (!buzz) m_enbz[k] = m_lat[k][0];
      if (!so)   m_enco[k] = m_lat[k][1];
      if (!tclk) m_entc[k] = m_lat[k][3];
      if (we) begin
        if (addr < 3'd4) begin
          m_lat[k][addr[1:0]] = wdata;
          m_oef[k][addr[1:0]] = 1'b1;
        end else if (addr == 3'd4) begin
          m_ctl[k] = wdata;
        end
      end
    end
    if (sclk && !m_sq) m_cnt = m_cnt + 2'd1;
    m_sq = sclk;
  endtask

  task automatic step(bit w, bit [2:0] a, bit d, bit bz, bit f, bit s, bit t, bit r);
    @(posedge clk);
    if (rst_ni) model_step(); else model_reset();
    #2;
    we = w; addr = a; wdata = d; buzz = bz; fclk = f; sclk = s; tclk = t; srdy = r;
    #6;
    check_all();
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst_ni = 1'b0; we = 0; addr = 0; wdata = 0; buzz = 0; fclk = 0; sclk = 0; tclk = 0; srdy = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    #6 check_all();  // R1 R9 reset state
    for (int a = 0; a < 6; a++) step(0, 3'(a), 0, 0, 0, 0, 0, 0); // R1 reset readback

    // R3: latch set while tone high must wait for a low sample
    step(1, 3'd0, 1, 1, 0, 0, 0, 0);
    step(0, 3'd0, 0, 1, 0, 0, 0, 0);
    step(0, 3'd0, 0, 1, 0, 0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0, 0, 0);
    step(0, 3'd0, 0, 1, 0, 0, 0, 0);
    // R2: partner latch written, no effect on inverted tone
    step(1, 3'd1, 1, 1, 0, 0, 0, 0);
    step(0, 3'd1, 0, 0, 0, 0, 0, 0);
    // R7: control on, latch 3 on, timer toggling; then control off
    step(1, 3'd4, 1, 0, 0, 0, 0, 0);
    step(1, 3'd3, 1, 0, 0, 0, 0, 0);
    for (int n = 0; n < 6; n++) step(0, 3'd3, 0, 0, 0, 0, n[0], 0);
    step(1, 3'd4, 0, 0, 0, 0, 1, 0);
    step(0, 3'd4, 0, 0, 0, 0, 1, 0);
    // R1: unmapped address write ignored
    step(1, 3'd5, 1, 0, 0, 0, 0, 0);
    step(0, 3'd5, 0, 0, 0, 0, 0, 0);

    // random phase, R2 R5 R6 R8 R10 and all above
    for (int n = 0; n < 4000; n++) begin
      bit w  = ($urandom % 4) == 0;
      bit [2:0] a = 3'($urandom % 6);
      bit d  = 1'($urandom);
      bit bz = (($urandom % 3) == 0) ? ~buzz : buzz;
      bit s  = (($urandom % 3) == 0) ? ~sclk : sclk;
      bit t  = (($urandom % 2) == 0) ? ~tclk : tclk;
      bit r  = (($urandom % 5) == 0) ? ~srdy : srdy;
      step(w, a, d, bz, ~fclk, s, t, r);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule